// File: doc/BRIEF.md
# Warp Divergence Lane-Mask Stack

This block holds the active-lane mask of one warp of SIMD lanes while the warp runs through nested data-dependent branches. Every lane executes every instruction. The mask only chooses which lanes are allowed to commit their results. Each lane supplies a one-bit predicate, which a compare instruction produces. The instruction stream supplies one of four commands:

- **Diverge** enters the taken side of a branch.
- **Flip** enters the other side.
- **Rejoin** marks the reconvergence point.
- **Idle** does nothing.

On a diverge, the current mask is saved on an internal LIFO of lane masks, and the live mask narrows to the lanes that were active and whose predicate is true. A flip leaves the stack as it is. It rebuilds the live mask from the saved parent mask, taking the parent lanes whose predicate is false; the issuer presents the same predicate as on the matching diverge. A rejoin restores the saved parent mask and removes it from the stack.

A side of a branch may end up with no active lane. In that case a one-cycle skip hint tells the fetch logic that the path can be jumped over. A diverge while the stack is full, or a flip or rejoin while it is empty, is refused. A refused command leaves the mask and the stack untouched and raises an error flag that stays set until reset. All outputs are registered: a command sampled at a rising clock edge is visible just after that edge.

Top module: `wmask_top`

## Requirements
- R1: After reset, `active_mask` is all ones, `nest_level` is 0, and `skip_hint` and `stack_err` are 0.
- R2: A diverge (`cmd_op` = 2'b01) while `nest_level` < DEPTH saves the current mask. On the next cycle `active_mask` equals the old mask AND `lane_pred`, and `nest_level` has risen by one.
- R3: A flip (`cmd_op` = 2'b10) while `nest_level` > 0 makes `active_mask` equal to the most recently saved mask AND NOT `lane_pred`. `nest_level` does not change.
- R4: A rejoin (`cmd_op` = 2'b11) while `nest_level` > 0 restores `active_mask` to the most recently saved mask and lowers `nest_level` by one.
- R5: Saved masks nest in last-in first-out order, up to DEPTH levels, and `nest_level` never exceeds DEPTH.
- R6: A diverge while `nest_level` = DEPTH is refused. `stack_err` becomes 1, and `active_mask` and `nest_level` keep their values.
- R7: A flip or rejoin while `nest_level` = 0 is refused. `stack_err` becomes 1, and `active_mask` and `nest_level` keep their values.
- R8: Once set, `stack_err` stays 1 until reset, whatever commands follow.
- R9: `skip_hint` is 1 for exactly the one cycle after an accepted diverge or flip whose resulting mask is all zeros. Otherwise it is 0.
- R10: With `cmd_valid` = 0, or with `cmd_op` = 2'b00 (idle), nothing changes and `skip_hint` is 0.
- R11: `lane_pred` has no effect on idle or rejoin commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 idle, 01 diverge, 10 flip, 11 rejoin |
| lane_pred | input | LANES | Per-lane predicate bits |
| active_mask | output | LANES | Lanes allowed to commit results |
| nest_level | output | $clog2(DEPTH+1) | Number of saved masks |
| skip_hint | output | 1 | The path just entered has no active lane |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench fills the stack to its last level and then pushes once more. A design with an off-by-one full test would either corrupt a saved mask or refuse a legal nest one level too early. It also sends a flip and a rejoin on an empty stack: a design that accepted them would read a stale entry and change the mask. A flip after a nested diverge checks that the else mask is built from the parent rather than from the live mask; a wrong design would lose lanes that a deeper branch had already turned off. A long mixed command sequence with varied predicates confirms that the order of restores is strictly last-in first-out. It also confirms that the skip hint fires only for empty paths, and only for one cycle.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
   typedef enum logic [1:0] {
      OP_IDLE    = 2'b00,
      OP_DIVERGE = 2'b01,
      OP_FLIP    = 2'b10,
      OP_REJOIN  = 2'b11
   } mask_op_e;
endpackage

// File: rtl/wmask_store.sv
module wmask_store #(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LANES-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [LANES-1:0] rd_data
);
   logic [DEPTH-1:0][LANES-1:0] slot_flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [LANES-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            q <= wr_data;
         end
      end
      assign slot_flat[i] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_data = slot_flat[i];
         end
      end
   end
endmodule

// File: rtl/wmask_decide.sv
module wmask_decide
   import wmask_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             op_valid,
   input  mask_op_e         op,
   input  logic [LANES-1:0] cur_mask,
   input  logic [LANES-1:0] parent_mask,
   input  logic [LANES-1:0] pred,
   input  logic [LVL_W-1:0] level,
   output logic [LANES-1:0] nxt_mask,
   output logic [LVL_W-1:0] nxt_level,
   output logic             do_push,
   output logic             reject,
   output logic             zero_path
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic [LANES-1:0] taken_mask;
   logic [LANES-1:0] other_mask;
   logic             is_full;
   logic             is_empty;

   assign taken_mask = cur_mask & pred;
   assign other_mask = parent_mask & ~pred;
   assign is_full    = (level == FULL_LVL);
   assign is_empty   = (level == '0);

   always_comb begin
      nxt_mask  = cur_mask;
      nxt_level = level;
      do_push   = 1'b0;
      reject    = 1'b0;
      zero_path = 1'b0;
      if (op_valid) begin
         unique case (op)
            OP_DIVERGE: begin
               if (is_full) begin
                  reject = 1'b1;
               end else begin
                  do_push   = 1'b1;
                  nxt_mask  = taken_mask;
                  nxt_level = level + 1'b1;
                  zero_path = ~|taken_mask;
               end
            end
            OP_FLIP: begin
               if (is_empty) begin
                  reject = 1'b1;
               end else begin
                  nxt_mask  = other_mask;
                  zero_path = ~|other_mask;
               end
            end
            OP_REJOIN: begin
               if (is_empty) begin
                  reject = 1'b1;
               end else begin
                  nxt_mask  = parent_mask;
                  nxt_level = level - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wmask_top.sv
module wmask_top
   import wmask_pkg::*;
#(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [LANES-1:0] lane_pred,
   output logic [LANES-1:0] active_mask,
   output logic [LVL_W-1:0] nest_level,
   output logic             skip_hint,
   output logic             stack_err
);
   if (LANES < 1) begin : g_bad_lanes
      $error("wmask_top: LANES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("wmask_top: DEPTH must be at least 2");
   end

   logic [LANES-1:0] mask_q;
   logic [LANES-1:0] parent_mask;
   logic [LANES-1:0] nxt_mask;
   logic [LVL_W-1:0] lvl_q;
   logic [LVL_W-1:0] nxt_lvl;
   logic             push_en;
   logic             reject;
   logic             zero_path;
   logic             skip_q;
   logic             err_q;

   wmask_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_en),
      .wr_idx  (IDX_W'(lvl_q)),
      .wr_data (mask_q),
      .rd_idx  (IDX_W'(lvl_q - 1'b1)),
      .rd_data (parent_mask)
   );

   wmask_decide #(.LANES(LANES), .DEPTH(DEPTH)) u_decide (
      .op_valid    (cmd_valid),
      .op          (mask_op_e'(cmd_op)),
      .cur_mask    (mask_q),
      .parent_mask (parent_mask),
      .pred        (lane_pred),
      .level       (lvl_q),
      .nxt_mask    (nxt_mask),
      .nxt_level   (nxt_lvl),
      .do_push     (push_en),
      .reject      (reject),
      .zero_path   (zero_path)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         lvl_q  <= '0;
         skip_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         mask_q <= nxt_mask;
         lvl_q  <= nxt_lvl;
         skip_q <= zero_path;
         err_q  <= err_q | reject;
      end
   end

   assign active_mask = mask_q;
   assign nest_level  = lvl_q;
   assign skip_hint   = skip_q;
   assign stack_err   = err_q;
endmodule

// File: rtl/wmask_chk.sv
module wmask_chk #(
   parameter int LANES = 32,
   parameter int DEPTH = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic [LANES-1:0] active_mask,
   input logic [LVL_W-1:0] nest_level,
   input logic             skip_hint,
   input logic             stack_err
);
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(DEPTH);

   // R2
   push_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && nest_level < TOP_LVL) |=>
      (((active_mask & ~$past(active_mask)) == '0) && (nest_level == $past(nest_level) + 1'b1)));

   // R3
   flip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b10 && nest_level != '0) |=> $stable(nest_level));

   // R5
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nest_level <= TOP_LVL);

   // R6
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && nest_level == TOP_LVL) |=>
      (stack_err && $stable(active_mask) && $stable(nest_level)));

   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op[1] && nest_level == '0) |=>
      (stack_err && $stable(active_mask) && $stable(nest_level)));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err |=> stack_err);

   // R9
   skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_hint |-> (active_mask == '0));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid || cmd_op == 2'b00) |=>
      ($stable(active_mask) && $stable(nest_level) && !skip_hint));
endmodule

bind wmask_top wmask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/wmask_top_tb_top.sv
`timescale 1ns/1ps
module wmask_top_tb_top;
   localparam int LANES = 32;
   localparam int DEPTH = 8;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [1:0]       cmd_op = 2'b00;
   logic [LANES-1:0] lane_pred = '0;
   logic [LANES-1:0] active_mask;
   logic [LVL_W-1:0] nest_level;
   logic             skip_hint;
   logic             stack_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [LANES-1:0] m_stk[$];
   logic [LANES-1:0] m_mask;
   logic             m_err;
   logic             m_skip;

   always #4 clk = ~clk;

   wmask_top #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .lane_pred(lane_pred), .active_mask(active_mask), .nest_level(nest_level),
      .skip_hint(skip_hint), .stack_err(stack_err)
   );

   task automatic compare(input string tag);
      checks++;
      if (active_mask !== m_mask || nest_level !== LVL_W'(m_stk.size()) ||
          skip_hint !== m_skip || stack_err !== m_err) begin
         fails++;
         $display("FAIL %s mask=%h exp=%h level=%0d exp=%0d skip=%b exp=%b err=%b exp=%b",
                  tag, active_mask, m_mask, nest_level, m_stk.size(),
                  skip_hint, m_skip, stack_err, m_err);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      cmd_op = 2'b00;
      repeat (2) @(negedge clk);
      m_stk.delete();
      m_mask = '1;
      m_err = 1'b0;
      m_skip = 1'b0;
      rst_n = 1'b1;
      compare("R1");
   endtask

   // inputs driven at the falling edge, outputs compared at the next falling edge
   task automatic step(input logic v, input logic [1:0] op,
                       input logic [LANES-1:0] p, input string tag);
      cmd_valid = v;
      cmd_op = op;
      lane_pred = p;
      m_skip = 1'b0;
      if (v) begin
         case (op)
            2'b01: if (m_stk.size() == DEPTH) m_err = 1'b1;
                   else begin
                      m_stk.push_back(m_mask);
                      m_mask = m_mask & p;
                      m_skip = (m_mask == '0);
                   end
            2'b10: if (m_stk.size() == 0) m_err = 1'b1;
                   else begin
                      m_mask = m_stk[$] & ~p;
                      m_skip = (m_mask == '0);
                   end
            2'b11: if (m_stk.size() == 0) m_err = 1'b1;
                   else m_mask = m_stk.pop_back();
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      logic [31:0] lfsr;
      @(negedge clk);
      do_reset();
      step(1, 2'b01, 32'h0000_FFFF, "R2");
      step(1, 2'b01, 32'h00FF_00FF, "R2");
      step(1, 2'b10, 32'h00FF_00FF, "R3");
      step(1, 2'b11, 32'hDEAD_BEEF, "R4");
      step(1, 2'b00, 32'h1234_5678, "R10");
      step(0, 2'b01, 32'h0000_0000, "R10");
      step(1, 2'b10, 32'h0000_FFFF, "R9");
      step(1, 2'b00, 32'h0, "R9");
      step(1, 2'b11, 32'hFFFF_FFFF, "R11");
      step(1, 2'b11, 32'h0, "R7");
      step(1, 2'b10, 32'h0, "R7");
      step(1, 2'b01, 32'hF0F0_F0F0, "R8");
      step(1, 2'b11, 32'h0, "R8");
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 2'b01, ~(32'h1 << i), "R5");
      end
      step(1, 2'b01, 32'hFFFF_FFFF, "R6");
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 2'b11, 32'h5555_5555, "R5");
      end
      do_reset();
      step(1, 2'b01, 32'h0, "R9");
      step(1, 2'b01, 32'hFFFF_FFFF, "R9");
      step(1, 2'b11, 32'h0, "R4");
      step(1, 2'b10, 32'h0, "R3");
      step(1, 2'b11, 32'h0, "R4");
      do_reset();
      lfsr = 32'hACE1_2345;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[3:0] != 4'h0, lfsr[5:4], lfsr ^ {lfsr[15:0], lfsr[31:16]}, "R5");
         if (m_err && lfsr[9:6] == 4'h0) do_reset();
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule